// File: doc/BRIEF.md
# Programmable Timer Channel

A single timer channel with a 32-bit up-counter that advances on a per-channel tick enable. It runs either periodically or once. Software reaches it through decoded write strobes that share one data bus. Three of the strobes are bare commands: reset, start and stop. The other four write registers: mode, terminal count, interrupt enable and interrupt acknowledge.

The channel shows its live count, the terminal count it holds and an 8-bit status word. It also drives a level interrupt. Periodic mode with a terminal count of all ones turns the channel into a free-running timestamp counter. One-shot mode with a freshly written count gives a single deadline event.

Top module: `tmr_channel`

## Requirements
- R1: After asynchronous reset the count is 0, the terminal count is all ones, the status word is 0x01 and the interrupt is low.
- R2: The status word holds the state code in bits [3:0] (1 = idle, 2 = active), the enable flag in bit 4, the mode in bit 5 (1 = one-shot), the interrupt enable in bit 6 and the pending flag in bit 7.
- R3: While the channel is active, each cycle with the tick enable high adds one to the count. A cycle without a tick leaves the count unchanged.
- R4: A start strobe sets the enable flag and makes the channel active. A stop strobe clears the enable flag and makes it idle. Neither strobe looks at the data bus. An idle channel holds its count.
- R5: A tick that would take the count to the terminal count instead returns the count to 0 and sets pending. With a terminal count of 1, every tick is an event.
- R6: In one-shot mode an event also makes the channel idle. The enable flag stays set and counting stops.
- R7: In periodic mode the channel keeps counting after each event. It fires once every terminal-count ticks.
- R8: A reset strobe clears the count, the pending flag and the enable flag, and forces idle. It keeps the terminal count, mode and interrupt enable. Among the commands, reset wins over stop, and stop wins over start.
- R9: An acknowledge write clears pending only when data bit 7 is 1. An event in the same cycle keeps pending set.
- R10: The interrupt enable write takes data bit 0. The interrupt output is high exactly when pending and interrupt enable are both 1.
- R11: The mode write takes data bit 0 (0 = periodic, 1 = one-shot). The terminal count write takes all 32 data bits, and the value reads back on the terminal count output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick enable, one cycle per tick |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_start | input | 1 | Start command strobe |
| cmd_stop | input | 1 | Stop command strobe |
| wr_mode | input | 1 | Mode register write strobe |
| wr_tc | input | 1 | Terminal count write strobe |
| wr_ie | input | 1 | Interrupt enable write strobe |
| wr_ack | input | 1 | Interrupt acknowledge write strobe |
| wr_data | input | 32 | Shared write data |
| count_o | output | 32 | Current count |
| tc_o | output | 32 | Terminal count held |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that each strobe is a single-cycle, synchronous pulse. They also assume that several strobes may arrive in the same cycle, and they depend on the stated priority in that case. The bench raises strobes with low probability, lets them collide freely, and keeps random terminal counts small so that events, one-shot expiries and acknowledge races happen often. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd1,
    ST_ACTIVE = 4'd2
  } tmr_state_e;

  localparam int STAT_W      = 8;
  localparam int BIT_EN      = 4;
  localparam int BIT_MODE    = 5;
  localparam int BIT_IE      = 6;
  localparam int BIT_PEND    = 7;
  localparam int ACK_BIT     = 7;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_ce;

  always_comb begin
    cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    hit     = step && (cnt_inc == tc);
    cnt_ce  = clr || step;
    if (clr)      cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cmd_reset,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             wr_mode,
  input  logic             wr_tc,
  input  logic             wr_ie,
  input  logic             wr_ack,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             hit,
  output tmr_state_e       state,
  output logic             en,
  output logic             mode,
  output logic             ie,
  output logic             pend,
  output logic [CNT_W-1:0] tc,
  output logic             step
);
  tmr_state_e       state_q, state_d;
  logic             en_q, en_d, mode_q, mode_d, ie_q, ie_d, pend_q, pend_d;
  logic [CNT_W-1:0] tc_q, tc_d;

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    mode_d  = mode_q;
    ie_d    = ie_q;
    tc_d    = tc_q;
    if (wr_mode) mode_d = wr_data[0];
    if (wr_ie)   ie_d   = wr_data[0];
    if (wr_tc)   tc_d   = wr_data;
    if (cmd_reset) begin
      state_d = ST_IDLE;
      en_d    = 1'b0;
    end else if (cmd_stop) begin
      state_d = ST_IDLE;
      en_d    = 1'b0;
    end else if (cmd_start) begin
      state_d = ST_ACTIVE;
      en_d    = 1'b1;
    end else if (hit && mode_q) begin
      state_d = ST_IDLE;
    end
    if (cmd_reset)                         pend_d = 1'b0;
    else if (hit)                          pend_d = 1'b1;
    else if (wr_ack && wr_data[ACK_BIT])   pend_d = 1'b0;
    else                                   pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
      tc_q    <= '1;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      if (wr_mode) mode_q <= mode_d;
      if (wr_ie)   ie_q   <= ie_d;
      if (wr_tc)   tc_q   <= tc_d;
    end
  end

  assign step  = (state_q == ST_ACTIVE) && tick_en && !cmd_reset && !cmd_stop;
  assign state = state_q;
  assign en    = en_q;
  assign mode  = mode_q;
  assign ie    = ie_q;
  assign pend  = pend_q;
  assign tc    = tc_q;

  // R9: acknowledge with bit 7 and no competing event clears pending
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_data[ACK_BIT] && !hit && !cmd_reset) |=> !pend_q);
  // R6: one-shot event without a start strobe leaves the channel idle
  assert_oneshot_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q && !cmd_start) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               cmd_reset,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic               wr_mode,
  input  logic               wr_tc,
  input  logic               wr_ie,
  input  logic               wr_ack,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   tc_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               irq_o
);
  tmr_state_e       state;
  logic             en, mode, ie, pend, step, hit;
  logic [CNT_W-1:0] tc, cnt;

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cmd_reset(cmd_reset), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .wr_mode(wr_mode), .wr_tc(wr_tc), .wr_ie(wr_ie), .wr_ack(wr_ack),
    .wr_data(wr_data), .hit(hit),
    .state(state), .en(en), .mode(mode), .ie(ie), .pend(pend),
    .tc(tc), .step(step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(cmd_reset),
    .tc(tc), .cnt(cnt), .hit(hit)
  );

  always_comb begin
    status_o           = '0;
    status_o[3:0]      = state;
    status_o[BIT_EN]   = en;
    status_o[BIT_MODE] = mode;
    status_o[BIT_IE]   = ie;
    status_o[BIT_PEND] = pend;
  end

  assign count_o = cnt;
  assign tc_o    = tc;
  assign irq_o   = pend & ie;

  // R2: state field only ever carries one of the two codes
  assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:0] == 4'd1) || (status_o[3:0] == 4'd2));
  // R4: idle channel holds its count unless a reset strobe clears it
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o[3:0] == 4'd1) && !cmd_reset) |=> $stable(count_o));
  // R3: no tick, no movement
  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cmd_reset) |=> $stable(count_o));
  // R8: reset strobe clears count and pending and forces idle
  assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> ((count_o == '0) && !status_o[BIT_PEND] && (status_o[3:0] == 4'd1)));
endmodule

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 0, cmd_reset = 0, cmd_start = 0, cmd_stop = 0;
  logic        wr_mode = 0, wr_tc = 0, wr_ie = 0, wr_ack = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o, tc_o;
  logic [7:0]  status_o;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_cnt, m_tc;
  bit m_act, m_en, m_mode, m_ie, m_pend;

  always #10 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cmd_reset(cmd_reset), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .wr_mode(wr_mode), .wr_tc(wr_tc), .wr_ie(wr_ie), .wr_ack(wr_ack),
    .wr_data(wr_data), .count_o(count_o), .tc_o(tc_o),
    .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, old_mode;
    logic [31:0] nxt;
    if (!rst_n) begin
      m_cnt = 0; m_tc = 32'hFFFF_FFFF; m_act = 0; m_en = 0;
      m_mode = 0; m_ie = 0; m_pend = 0;
    end else begin
      hit = 0;
      old_mode = m_mode;
      if (m_act && tick_en && !cmd_reset && !cmd_stop) begin
        nxt = m_cnt + 1;
        if (nxt == m_tc) begin m_cnt = 0; hit = 1; end
        else m_cnt = nxt;
      end
      if (cmd_reset) m_cnt = 0;
      if (wr_tc)   m_tc = wr_data;
      if (wr_mode) m_mode = wr_data[0];
      if (wr_ie)   m_ie = wr_data[0];
      if (cmd_reset)                  m_pend = 0;
      else if (hit)                   m_pend = 1;
      else if (wr_ack && wr_data[7])  m_pend = 0;
      if (cmd_reset || cmd_stop) begin m_act = 0; m_en = 0; end
      else if (cmd_start)        begin m_act = 1; m_en = 1; end
      else if (hit && old_mode)  m_act = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 count", count_o, m_cnt);
      chk("R11 tc", tc_o, m_tc);
      chk("R2 status", {24'd0, status_o},
          {24'd0, m_pend, m_ie, m_mode, m_en, (m_act ? 4'd2 : 4'd1)});
      chk("R10 irq", {31'd0, irq_o}, {31'd0, m_pend & m_ie});
    end
  end

  task automatic clr_in();
    tick_en = 0; cmd_reset = 0; cmd_start = 0; cmd_stop = 0;
    wr_mode = 0; wr_tc = 0; wr_ie = 0; wr_ack = 0; wr_data = '0;
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    clr_in();
    wr_data = d;
    case (sel)
      0: wr_tc = 1;
      1: wr_mode = 1;
      2: wr_ie = 1;
      3: wr_ack = 1;
      4: cmd_start = 1;
      5: cmd_stop = 1;
      default: cmd_reset = 1;
    endcase
    @(negedge clk);
    clr_in();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clr_in(); tick_en = 1;
    end
    @(negedge clk); clr_in();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    clr_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 tc", tc_o, 32'hFFFF_FFFF);
    chk("R1 status", {24'd0, status_o}, 32'h01);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R5 terminal count of one: event on the first tick
    wr(0, 32'd1); wr(2, 32'd1); wr(4, 32'd0);
    ticks(1);
    chk("R5 tc1 status", {24'd0, status_o}, 32'hD2);
    chk("R10 irq high", {31'd0, irq_o}, 1);
    // R9 acknowledge without bit 7 leaves pending
    wr(3, 32'h7F);
    chk("R9 ack bit7 clear", {31'd0, status_o[7]}, 1);
    wr(3, 32'h80);
    chk("R9 ack bit7 set", {31'd0, status_o[7]}, 0);

    // R7 periodic with tc=5: events at 5 and 10 ticks
    wr(0, 32'd5); wr(5, 32'd0); wr(4, 32'hFFFF_FFFF);
    ticks(4);
    chk("R7 count 4", count_o, 4);
    ticks(1);
    chk("R7 wrap", count_o, 0);
    wr(3, 32'h80);
    ticks(5);
    chk("R7 refire", {31'd0, status_o[7]}, 1);

    // R6 one-shot: stop after event, enable flag kept
    wr(1, 32'd1); wr(6, 32'd0); wr(0, 32'd3); wr(4, 32'd0);
    ticks(6);
    chk("R6 idle enabled", {24'd0, status_o}, 32'hF1);
    chk("R6 count held", count_o, 0);

    // R8 reset strobe keeps configuration
    wr(4, 32'd0); ticks(1);
    wr(6, 32'hFFFF_FFFF);
    chk("R8 tc kept", tc_o, 3);
    chk("R8 status", {24'd0, status_o}, 32'h61);

    // R4 stop with all-ones data; then idle holds
    wr(4, 32'hFFFF_FFFF); ticks(1);
    wr(5, 32'hFFFF_FFFF); ticks(3);
    chk("R4 stopped", {24'd0, status_o[4:0]}, 32'h01);
    chk("R4 held", count_o, 1);

    // R11 full-width terminal count write
    wr(0, 32'hA5C3_0F1E);
    chk("R11 tc write", tc_o, 32'hA5C3_0F1E);

    // mixed random stimulus, model compared every cycle
    wr(0, 32'd4);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      clr_in();
      tick_en   = ($urandom % 4) != 0;
      cmd_reset = ($urandom % 40) == 0;
      cmd_start = ($urandom % 8) == 0;
      cmd_stop  = ($urandom % 30) == 0;
      wr_mode   = ($urandom % 25) == 0;
      wr_ie     = ($urandom % 25) == 0;
      wr_ack    = ($urandom % 6) == 0;
      wr_tc     = ($urandom % 50) == 0;
      wr_data   = wr_tc ? (32'($urandom % 8)) : $urandom;
    end
    @(negedge clk); clr_in();
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule